// File: doc/BRIEF.md
# 4B5B Transmit Code-Group Encoder

This block sits on the 100 Mb/s twisted-pair transmit path between the MAC nibble interface and the scrambler. Each 25 MHz clock it takes one 4-bit transmit nibble together with its enable and error qualifiers. Each clock it produces one 5-bit code-group. Frames are wrapped in delimiters: the first two nibbles after the enable rises are overwritten by the start pair J/K. Every later nibble maps to its data code-group. The cycle after the enable drops opens the end pair T/R. Between frames the line is filled with IDLE.

An error flag raised inside a frame replaces that nibble with the HALT code-group. A bypass control turns the encoder into a plain register: the nibble is sent unencoded and framing returns to its idle state. The output is registered, so every code-group appears one clock after the inputs that chose it.

Top module: `tx_cg_encoder`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, `cg_out` is IDLE (11111).
- R2: When `tx_en` is sampled high with framing idle and `bypass` low, the next output is J (11000) and the one after it is K (10001). The nibbles sampled in those two cycles are discarded.
- R3: Every later nibble sampled with `tx_en` high and `tx_er` low appears one clock later as its data code-group. Nibbles 0 to F map to 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R4: A data-phase nibble sampled with both `tx_en` and `tx_er` high is replaced by HALT (00100).
- R5: The first cycle in which `tx_en` is sampled low after the data phase yields T (01101), and the following cycle yields R (00111). R is sent whatever `tx_en` does in that cycle, and a nibble offered then is dropped.
- R6: Outside a frame and its T/R pair, a cycle with `tx_en` low yields IDLE (11111).
- R7: With `bypass` high, the output one clock later is `{1'b0, tx_nibble}`, and framing returns to idle. A frame begun after bypass drops starts again with J/K.
- R8: `tx_er` has no effect during the J/K cycles or while `tx_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz transmit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_nibble | input | 4 | Transmit data nibble |
| tx_en | input | 1 | Frame enable |
| tx_er | input | 1 | Transmit error, forces HALT in the data phase |
| bypass | input | 1 | Send the raw nibble unencoded |
| cg_out | output | 5 | Registered 5-bit code-group |

## Verification
Assertions check the fixed sequences on every cycle: J is always followed by K, and T by R. They also check that an error in the data phase yields HALT, that idle cycles give IDLE, and that the bypass path reproduces the previous nibble. The bench scenarios are needed for the rest. These include the full data map for all sixteen nibbles, and the dropping of a nibble offered during R when the enable reasserts at once. They also cover restarting a frame after bypass, and the error flag having no effect in the delimiter cycles. These depend on frame history that only a reference model tracking whole frames can follow.

// File: rtl/cg4b5b_pkg.sv
package cg4b5b_pkg;

   localparam logic [4:0] CG_IDLE = 5'b11111;
   localparam logic [4:0] CG_J    = 5'b11000;
   localparam logic [4:0] CG_K    = 5'b10001;
   localparam logic [4:0] CG_T    = 5'b01101;
   localparam logic [4:0] CG_R    = 5'b00111;
   localparam logic [4:0] CG_HALT = 5'b00100;

   typedef enum logic [1:0] {
      FR_IDLE,
      FR_K,
      FR_DATA,
      FR_R
   } frame_st_t;

   typedef enum logic [2:0] {
      SEL_IDLE,
      SEL_J,
      SEL_K,
      SEL_DATA,
      SEL_HALT,
      SEL_T,
      SEL_R,
      SEL_RAW
   } cg_sel_t;

endpackage

// File: rtl/cg_data_map.sv
module cg_data_map
   import cg4b5b_pkg::*;
#(
   parameter int NIBBLE_W = 4,
   parameter int CODE_W   = 5
) (
   input  logic [NIBBLE_W-1:0] nibble,
   output logic [CODE_W-1:0]   code
);

   if (NIBBLE_W != 4 || CODE_W != 5) begin : g_bad_width
      $error("cg_data_map: 4B5B mapping needs NIBBLE_W=4 and CODE_W=5");
   end

   always_comb begin
      case (nibble)
         4'h0: code = 5'b11110;
         4'h1: code = 5'b01001;
         4'h2: code = 5'b10100;
         4'h3: code = 5'b10101;
         4'h4: code = 5'b01010;
         4'h5: code = 5'b01011;
         4'h6: code = 5'b01110;
         4'h7: code = 5'b01111;
         4'h8: code = 5'b10010;
         4'h9: code = 5'b10011;
         4'hA: code = 5'b10110;
         4'hB: code = 5'b10111;
         4'hC: code = 5'b11010;
         4'hD: code = 5'b11011;
         4'hE: code = 5'b11100;
         default: code = 5'b11101;
      endcase
   end

endmodule

// File: rtl/cg_frame_ctl.sv
module cg_frame_ctl
   import cg4b5b_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      tx_en,
   input  logic      tx_er,
   input  logic      bypass,
   output cg_sel_t   sel,
   output frame_st_t state
);

   frame_st_t state_d;

   always_comb begin
      state_d = state;
      sel     = SEL_IDLE;
      if (bypass) begin
         sel     = SEL_RAW;
         state_d = FR_IDLE;
      end else begin
         case (state)
            FR_IDLE: begin
               if (tx_en) begin
                  sel     = SEL_J;
                  state_d = FR_K;
               end
            end
            FR_K: begin
               sel     = SEL_K;
               state_d = FR_DATA;
            end
            FR_DATA: begin
               if (tx_en) begin
                  sel = tx_er ? SEL_HALT : SEL_DATA;
               end else begin
                  sel     = SEL_T;
                  state_d = FR_R;
               end
            end
            default: begin
               sel     = SEL_R;
               state_d = FR_IDLE;
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= FR_IDLE;
      else        state <= state_d;
   end

   // R2: the K state is only ever entered from idle
   p_k_from_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == FR_K) |-> ($past(state) == FR_IDLE));

   // R5: the R state is always left for idle after one cycle
   p_r_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == FR_R) |=> (state == FR_IDLE));

endmodule

// File: rtl/tx_cg_encoder.sv
module tx_cg_encoder
   import cg4b5b_pkg::*;
#(
   parameter int NIBBLE_W  = 4,
   parameter int CODE_W    = 5,
   parameter bit BYPASS_EN = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NIBBLE_W-1:0] tx_nibble,
   input  logic                tx_en,
   input  logic                tx_er,
   input  logic                bypass,
   output logic [CODE_W-1:0]   cg_out
);

   localparam int PAD_W = CODE_W - NIBBLE_W;

   if (PAD_W != 1) begin : g_bad_pad
      $error("tx_cg_encoder: code-group must be one bit wider than the nibble");
   end

   logic              byp_eff;
   logic [CODE_W-1:0] data_code;
   logic [CODE_W-1:0] raw_code;
   logic [CODE_W-1:0] cg_q;
   cg_sel_t           sel;
   frame_st_t         fr_state;

   if (BYPASS_EN) begin : g_bypass
      assign byp_eff = bypass;
   end else begin : g_no_bypass
      logic unused_byp;
      assign unused_byp = bypass;
      assign byp_eff    = 1'b0;
   end

   assign raw_code = {{PAD_W{1'b0}}, tx_nibble};

   cg_data_map #(.NIBBLE_W(NIBBLE_W), .CODE_W(CODE_W)) u_map (
      .nibble (tx_nibble),
      .code   (data_code)
   );

   cg_frame_ctl u_ctl (
      .clk    (clk),
      .rst_n  (rst_n),
      .tx_en  (tx_en),
      .tx_er  (tx_er),
      .bypass (byp_eff),
      .sel    (sel),
      .state  (fr_state)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cg_q <= CG_IDLE;
      end else begin
         case (sel)
            SEL_J:    cg_q <= CG_J;
            SEL_K:    cg_q <= CG_K;
            SEL_DATA: cg_q <= data_code;
            SEL_HALT: cg_q <= CG_HALT;
            SEL_T:    cg_q <= CG_T;
            SEL_R:    cg_q <= CG_R;
            SEL_RAW:  cg_q <= raw_code;
            default:  cg_q <= CG_IDLE;
         endcase
      end
   end

   assign cg_out = cg_q;

   p_jk_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cg_out == CG_J && !byp_eff) |=> (cg_out == CG_K));

   p_halt_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (fr_state == FR_DATA && tx_en && tx_er && !byp_eff) |=> (cg_out == CG_HALT));

   p_tr_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cg_out == CG_T && !$past(byp_eff) && !byp_eff) |=> (cg_out == CG_R));

   p_idle_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fr_state == FR_IDLE && !tx_en && !byp_eff) |=> (cg_out == CG_IDLE));

   p_raw_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
      byp_eff |=> (cg_out == {{PAD_W{1'b0}}, $past(tx_nibble)}));

endmodule

// File: tb/tx_cg_encoder_bench.sv
`timescale 1ns/1ps
module tx_cg_encoder_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] tx_nibble = 4'h0;
   logic       tx_en = 1'b0;
   logic       tx_er = 1'b0;
   logic       bypass = 1'b0;
   logic [4:0] cg_out;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   int         m_st = 0;
   logic [4:0] exp_cg;
   string      exp_tag;

   always #2.5 clk = ~clk;

   tx_cg_encoder u_tx_cg_encoder (
      .clk       (clk),
      .rst_n     (rst_n),
      .tx_nibble (tx_nibble),
      .tx_en     (tx_en),
      .tx_er     (tx_er),
      .bypass    (bypass),
      .cg_out    (cg_out)
   );

   function automatic logic [4:0] ref_code(input logic [3:0] n);
      case (n)
         4'h0: return 5'b11110;  4'h1: return 5'b01001;
         4'h2: return 5'b10100;  4'h3: return 5'b10101;
         4'h4: return 5'b01010;  4'h5: return 5'b01011;
         4'h6: return 5'b01110;  4'h7: return 5'b01111;
         4'h8: return 5'b10010;  4'h9: return 5'b10011;
         4'hA: return 5'b10110;  4'hB: return 5'b10111;
         4'hC: return 5'b11010;  4'hD: return 5'b11011;
         4'hE: return 5'b11100;  default: return 5'b11101;
      endcase
   endfunction

   task automatic check(input logic [4:0] exp, input string tag);
      n_tests++;
      if (cg_out !== exp) begin
         n_fail++;
         $display("FAIL %s: cg_out=%b expected=%b", tag, cg_out, exp);
      end
   endtask

   // reference model: one input cycle, expected output one clock later
   task automatic step(input logic en, input logic er, input logic [3:0] d,
                       input logic byp);
      tx_en = en; tx_er = er; tx_nibble = d; bypass = byp;
      if (byp) begin
         exp_cg = {1'b0, d}; m_st = 0; exp_tag = "R7";
      end else begin
         case (m_st)
            0: if (en) begin
                  exp_cg = 5'b11000; m_st = 1; exp_tag = er ? "R8" : "R2";
               end else begin
                  exp_cg = 5'b11111; exp_tag = er ? "R8" : "R6";
               end
            1: begin exp_cg = 5'b10001; m_st = 2; exp_tag = er ? "R8" : "R2"; end
            2: if (en) begin
                  exp_cg = er ? 5'b00100 : ref_code(d);
                  exp_tag = er ? "R4" : "R3";
               end else begin
                  exp_cg = 5'b01101; m_st = 3; exp_tag = "R5";
               end
            default: begin exp_cg = 5'b00111; m_st = 0; exp_tag = "R5"; end
         endcase
      end
      @(posedge clk);
      @(negedge clk);
      check(exp_cg, exp_tag);
   endtask

   task automatic frame(input int len, input bit with_err);
      for (int i = 0; i < len; i++)
         step(1'b1, with_err && (i == len - 1), 4'(i), 1'b0);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h4b5b_0001));
      repeat (3) @(negedge clk);
      check(5'b11111, "R1 during reset");
      rst_n = 1'b1;
      @(posedge clk); @(negedge clk);
      check(5'b11111, "R1 after release");

      // R2/R3: frame covering all sixteen nibbles after J/K
      step(1'b1, 1'b0, 4'h5, 1'b0);
      step(1'b1, 1'b0, 4'h5, 1'b0);
      for (int i = 0; i < 16; i++) step(1'b1, 1'b0, 4'(i), 1'b0);
      step(1'b0, 1'b0, 4'h0, 1'b0);   // T (R5)
      step(1'b0, 1'b0, 4'h0, 1'b0);   // R (R5)
      step(1'b0, 1'b1, 4'h3, 1'b0);   // R6/R8 idle with error ignored

      // R8: error in J/K cycles ignored, R4 halt in data
      step(1'b1, 1'b1, 4'h1, 1'b0);
      step(1'b1, 1'b1, 4'h2, 1'b0);
      step(1'b1, 1'b1, 4'h3, 1'b0);
      step(1'b1, 1'b0, 4'h4, 1'b0);
      // R5: enable reasserted during T/R, nibble during R dropped
      step(1'b0, 1'b0, 4'h0, 1'b0);
      step(1'b1, 1'b0, 4'h9, 1'b0);
      step(1'b1, 1'b0, 4'h9, 1'b0);   // J again
      step(1'b1, 1'b0, 4'h9, 1'b0);   // K
      step(1'b1, 1'b0, 4'h7, 1'b0);
      // R7: bypass mid-frame, then restart with J/K
      step(1'b1, 1'b0, 4'hD, 1'b1);
      step(1'b1, 1'b1, 4'h6, 1'b1);
      step(1'b1, 1'b0, 4'hA, 1'b0);
      step(1'b1, 1'b0, 4'hA, 1'b0);
      step(1'b1, 1'b0, 4'hA, 1'b0);
      step(1'b0, 1'b0, 4'h0, 1'b0);
      step(1'b0, 1'b0, 4'h0, 1'b0);
      frame(6, 1'b1);
      step(1'b0, 1'b0, 4'h0, 1'b0);

      // constrained random traffic
      for (int f = 0; f < 400; f++) begin
         int gap = $urandom_range(0, 3);
         int len = $urandom_range(1, 24);
         for (int g = 0; g < gap; g++)
            step(1'b0, 1'($urandom_range(0, 1)), 4'($urandom), 1'($urandom_range(0, 19) == 0));
         for (int i = 0; i < len; i++)
            step(1'b1, 1'($urandom_range(0, 15) == 0), 4'($urandom),
                 1'($urandom_range(0, 39) == 0));
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule